// File: doc/BRIEF.md
# First-Peak Capture for a Shaped Pulse Stream

This block watches a stream of digitized, baseline-corrected shaper samples for a single channel. It arms when a sample rises above a threshold. The threshold is the sum of a global value and a small per-channel trim. While armed, it tracks the running maximum. When a sample first drops below that maximum while still above the threshold, it captures the maximum and the index of the sample that first reached it. The captured result stays on the outputs until a clear arrives.

Locking onto the first local maximum, instead of the largest value in a window, means a second, higher pulse that piles up on the tail of the first cannot replace the first amplitude. While a result is held, every new sample is consumed and discarded. A readout controller, or a pile-up reject path, pulses the clear input to re-open the channel.

The sample input is a valid/ready stream that never applies back-pressure. The ready signal is low only during reset and from then on stays high. A sample is taken on every clock edge where valid and ready are both high. Data presented while valid is low has no effect.

Top module: `fpd_first_peak`

## Requirements
- R1: `smp_ready` is low while `rst_n` is low and high from the first clock edge after reset is released. A sample is accepted on each edge where `smp_valid` and `smp_ready` are both high.
- R2: In the idle state, an accepted sample arms the search only if it is strictly greater than `thr_base + thr_trim`, summed without overflow. A sample equal to that sum does not arm.
- R3: While armed, the first accepted sample that is strictly below the running maximum and still above the threshold captures the running maximum into `pk_amp`. The capture is visible on the edge that accepts that sample.
- R4: A sample equal to the running maximum is not a slope change. `pk_time` reports the index of the first sample that reached the maximum.
- R5: Once a result is held (`pk_ready` high), later samples, including higher peaks, change none of the outputs until a clear.
- R6: While armed, an accepted sample at or below the threshold disarms the search without a capture. `pk_ready` stays low.
- R7: `pk_strobe` is high for exactly one cycle per capture, in the first cycle that `pk_ready` is high.
- R8: `pk_amp` and `pk_time` stay stable for as long as `pk_ready` stays high.
- R9: `clr` high on a clock edge returns the block to idle from any state. It takes priority over a capture on the same edge and drops `pk_ready`. `pk_amp` and `pk_time` keep their last values.
- R10: After reset, `pk_ready`, `pk_strobe`, `pk_amp` and `pk_time` are all zero.
- R11: The sample index is the number of samples accepted since reset, modulo 2^TW. Cycles with `smp_valid` low do not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high except in reset) |
| smp_data | input | SW | Unsigned shaped sample |
| thr_base | input | TGW | Global threshold |
| thr_trim | input | TRW | Per-channel threshold trim added to the global value |
| clr | input | 1 | Clear held result and re-open the channel |
| pk_amp | output | SW | Held peak amplitude |
| pk_time | output | TW | Sample index of the held peak |
| pk_strobe | output | 1 | One-cycle capture pulse |
| pk_ready | output | 1 | A captured result is held |

## Verification
The hardest situation to reach from the ports is a pulse that loses its threshold crossing without ever turning over. The search must then disarm, with the threshold raised or the samples falling onto it at the running maximum. The random stimulus builds pulses with plateaus, sub-threshold dips and piled-up second peaks. Thresholds are drawn near the pulse levels, so both the disarm and the capture orderings occur. Random gaps in `smp_valid` and clears dropped in mid-pulse or mid-hold exercise the index count and the clear priority against a bench model.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HOLD  = 2'd2
  } fpd_state_e;
endpackage

// File: rtl/fpd_thresh.sv
module fpd_thresh #(
  parameter int TGW = 10,
  parameter int TRW = 3,
  parameter int CW  = 12,
  parameter bit REG = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TGW-1:0] base,
  input  logic [TRW-1:0] trim,
  output logic [CW-1:0]  thr
);
  logic [CW-1:0] sum;
  assign sum = CW'(base) + CW'(trim);

  generate
    if (REG) begin : g_reg
      logic [CW-1:0] thr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= sum;
      end
      assign thr = thr_q;
    end else begin : g_comb
      assign thr = sum;
    end
  endgenerate
endmodule

// File: rtl/fpd_stamp.sv
module fpd_stamp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  output logic [TW-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stamp <= '0;
    else if (acc) stamp <= stamp + 1'b1;
  end
endmodule

// File: rtl/fpd_core.sv
module fpd_core
  import fpd_pkg::*;
#(
  parameter int SW = 12,
  parameter int TW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [SW-1:0] smp,
  input  logic [CW-1:0] thr,
  input  logic          clr,
  input  logic [TW-1:0] stamp,
  output logic [SW-1:0] amp,
  output logic [TW-1:0] tstamp,
  output logic          strobe,
  output logic          held
);
  fpd_state_e    st;
  logic [SW-1:0] run_max;
  logic [TW-1:0] run_time;
  logic          above, falling, rising;

  assign above   = CW'(smp) > thr;
  assign falling = smp < run_max;
  assign rising  = smp > run_max;
  assign held    = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      run_max  <= '0;
      run_time <= '0;
      amp      <= '0;
      tstamp   <= '0;
      strobe   <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (clr) begin
        st <= ST_IDLE;
      end else if (acc) begin
        unique case (st)
          ST_IDLE: begin
            if (above) begin
              st       <= ST_ARMED;
              run_max  <= smp;
              run_time <= stamp;
            end
          end
          ST_ARMED: begin
            if (!above) begin
              st <= ST_IDLE;
            end else if (falling) begin
              st     <= ST_HOLD;
              amp    <= run_max;
              tstamp <= run_time;
              strobe <= 1'b1;
            end else if (rising) begin
              run_max  <= smp;
              run_time <= stamp;
            end
          end
          default: begin
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fpd_first_peak.sv
module fpd_first_peak #(
  parameter int SW      = 12,
  parameter int TGW     = 10,
  parameter int TRW     = 3,
  parameter int TW      = 16,
  parameter bit THR_REG = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  output logic           smp_ready,
  input  logic [SW-1:0]  smp_data,
  input  logic [TGW-1:0] thr_base,
  input  logic [TRW-1:0] thr_trim,
  input  logic           clr,
  output logic [SW-1:0]  pk_amp,
  output logic [TW-1:0]  pk_time,
  output logic           pk_strobe,
  output logic           pk_ready
);
  localparam int THW = ((TGW > TRW) ? TGW : TRW) + 1;
  localparam int CW  = (SW > THW) ? SW : THW;

  logic          ready_q;
  logic          acc;
  logic [CW-1:0] thr;
  logic [TW-1:0] stamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign acc       = smp_valid & ready_q;

  fpd_thresh #(.TGW(TGW), .TRW(TRW), .CW(CW), .REG(THR_REG)) thr_i (
    .clk(clk), .rst_n(rst_n), .base(thr_base), .trim(thr_trim), .thr(thr)
  );

  fpd_stamp #(.TW(TW)) stamp_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .stamp(stamp)
  );

  fpd_core #(.SW(SW), .TW(TW), .CW(CW)) core_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .smp(smp_data), .thr(thr),
    .clr(clr), .stamp(stamp), .amp(pk_amp), .tstamp(pk_time),
    .strobe(pk_strobe), .held(pk_ready)
  );
endmodule

// File: rtl/fpd_first_peak_chk.sv
module fpd_first_peak_chk #(
  parameter int SW = 12,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          clr,
  input logic [SW-1:0] pk_amp,
  input logic [TW-1:0] pk_time,
  input logic          pk_strobe,
  input logic          pk_ready
);
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);

  a_r3_capture_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    pk_strobe |-> $past(smp_valid && smp_ready && !clr));

  a_r5_no_second_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_ready && $past(pk_ready)) |-> !pk_strobe);

  a_r7_strobe_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pk_strobe |-> ($rose(pk_ready)));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    pk_strobe |=> !pk_strobe);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_ready && $past(pk_ready)) |-> ($stable(pk_amp) && $stable(pk_time)));

  a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pk_ready);
endmodule

bind fpd_first_peak fpd_first_peak_chk #(.SW(SW), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .clr(clr), .pk_amp(pk_amp), .pk_time(pk_time), .pk_strobe(pk_strobe),
  .pk_ready(pk_ready)
);

// File: tb/fpd_first_peak_tb_top.sv
`timescale 1ns/1ps
module fpd_first_peak_tb_top;
  localparam int SW = 12, TGW = 10, TRW = 3, TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [TGW-1:0] thr_base = 10'd100;
  logic [TRW-1:0] thr_trim = 3'd5;
  logic clr = 1'b0;
  logic smp_ready, pk_strobe, pk_ready;
  logic [SW-1:0] pk_amp;
  logic [TW-1:0] pk_time;

  always #2.5 clk = ~clk;

  fpd_first_peak #(.SW(SW), .TGW(TGW), .TRW(TRW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .thr_base(thr_base), .thr_trim(thr_trim), .clr(clr),
    .pk_amp(pk_amp), .pk_time(pk_time), .pk_strobe(pk_strobe), .pk_ready(pk_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 armed, 2 holding
  int m_st = 0, m_max = 0, m_rt = 0, m_cnt = 0, m_amp = 0, m_time = 0;
  bit m_strb = 0;

  function automatic int thr_val(int b, int t);
    return b + t;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(bit v, int d, bit c);
    int th;
    th = thr_val(int'(thr_base), int'(thr_trim));
    m_strb = 0;
    if (c) m_st = 0;
    else if (v) begin
      case (m_st)
        0: if (d > th) begin m_st = 1; m_max = d; m_rt = m_cnt; end
        1: begin
          if (d <= th) m_st = 0;
          else if (d < m_max) begin
            m_st = 2; m_amp = m_max; m_time = m_rt; m_strb = 1;
          end else if (d > m_max) begin m_max = d; m_rt = m_cnt; end
        end
        default: ;
      endcase
    end
    if (v) m_cnt = (m_cnt + 1) % (1 << TW);
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(bit v, int d, bit c);
    smp_valid = v; smp_data = SW'(d); clr = c;
    @(posedge clk);
    model(v, d, c);
    @(negedge clk);
    check("R5 flag", int'(pk_ready), int'(m_st == 2));
    check("R7 strobe", int'(pk_strobe), int'(m_strb));
    check("R3 amp", int'(pk_amp), m_amp);
    check("R4 R11 time", int'(pk_time), m_time);
  endtask

  task automatic pulse(int pk, int dip, int pk2, bit plateau);
    int lvl;
    for (int i = 1; i <= 4; i++) begin
      lvl = pk * i / 4;
      if ($urandom_range(0, 3) == 0) step(0, $urandom_range(0, 4095), 0);
      step(1, lvl, 0);
      if (plateau && i == 4) step(1, lvl, 0);
    end
    step(1, dip, 0);
    if (pk2 > 0) begin
      step(1, pk2, 0);
      step(1, pk2 / 2, 0);
    end
    step(1, 10, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R10 / R1: reset state
    @(negedge clk); @(negedge clk);
    check("R1 ready in reset", int'(smp_ready), 0);
    check("R10 flag", int'(pk_ready), 0);
    check("R10 strobe", int'(pk_strobe), 0);
    check("R10 amp", int'(pk_amp), 0);
    check("R10 time", int'(pk_time), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(smp_ready), 1);

    // threshold 105: R2 equal does not arm
    step(1, 50, 0);   // idx0
    step(1, 105, 0);  // idx1 equal, no arm
    step(1, 104, 0);  // idx2
    check("R2 no arm at equal", int'(pk_ready), 0);
    // R4 plateau, R11 gap
    step(1, 200, 0);  // idx3 arm
    step(0, 999, 0);  // gap, ignored
    step(1, 300, 0);  // idx4
    step(1, 300, 0);  // idx5 equal, no slope change
    check("R4 plateau no capture", int'(pk_ready), 0);
    step(1, 250, 0);  // idx6 capture
    check("R3 amp", int'(pk_amp), 300);
    check("R4 R11 time first max", int'(pk_time), 4);
    check("R7 strobe", int'(pk_strobe), 1);
    // R5 higher peak ignored, R8 stable
    step(1, 900, 0);
    step(1, 400, 0);
    check("R5 higher ignored", int'(pk_amp), 300);
    check("R7 strobe single", int'(pk_strobe), 0);
    check("R8 time stable", int'(pk_time), 4);
    // R9 clear
    step(0, 0, 1);
    check("R9 flag dropped", int'(pk_ready), 0);
    check("R9 amp kept", int'(pk_amp), 300);
    // R6 disarm
    step(1, 200, 0);
    step(1, 210, 0);
    step(1, 90, 0);
    check("R6 disarm no capture", int'(pk_ready), 0);
    step(1, 80, 0);
    check("R6 still idle", int'(pk_ready), 0);
    // R9 clear beats capture on same edge
    step(1, 300, 0);
    step(1, 200, 1);
    check("R9 clear priority", int'(pk_ready), 0);
    check("R9 no strobe", int'(pk_strobe), 0);

    // constrained random pulses
    for (int p = 0; p < 1500; p++) begin
      int pk, dip, pk2;
      thr_base = TGW'($urandom_range(60, 400));
      thr_trim = TRW'($urandom_range(0, 7));
      pk  = $urandom_range(40, 4000);
      dip = (pk * $urandom_range(30, 99)) / 100;
      pk2 = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(pk / 2, 4095);
      pulse(pk, dip, pk2, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) != 0) step(0, 0, 1);
      if ($urandom_range(0, 9) == 0) begin
        step(1, 2000, 0);
        step(1, 2100, 1);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule